// File: doc/BRIEF.md
# Machine-Check Error Bank Logger

This block holds the error-reporting registers of a processor's machine-check unit. These are a read-only capability word, a global control word, a global status word, and a parameterised array of error banks. Each bank has four 64-bit registers: control, status, address and miscellaneous. A hardware error source presents one error record per cycle on the injection port. The record carries a bank index, a status word, a global-status value, an address and a misc value. In the same cycle the block decides whether to record it, whether to mark an overflow, and whether to raise a machine-check interrupt or escalate to a system reset request.

Uncorrected and corrected errors take different paths. An uncorrected error can be masked by the global control word or by the bank's control word. If it arrives while a previous machine check is still in progress, or while machine-check delivery is disabled, it escalates to a sticky reset request. A corrected error never displaces a valid uncorrected record. It only marks that record as overflowed. Software reads and writes every register, except the capability word, through a single-cycle register port.

Top module: `mce_bank_logger`

## Requirements
- R1: An injection whose bank index is at or above the bank count has no effect on any register or output. The bank count is bits 7:0 of the capability word, limited to the number of implemented banks.
- R2: An injection whose status bit 63 (valid) is clear has no effect.
- R3: An uncorrected injection (status bit 61 set) is dropped without effect when capability bit 8 (global control present) is set and the global control word is not all ones.
- R4: An uncorrected injection is dropped without effect when the target bank's control word is not all ones.
- R5: An uncorrected injection that is not dropped asserts the reset request and records nothing if global status bit 2 (machine check in progress) is set or the `mce_en` input is low.
- R6: A corrected injection into a bank that is empty, or that holds a record with bit 61 clear, overwrites the bank status, address and misc. Status bit 62 (overflow) is set if the bank status was already valid. Global status is left unchanged.
- R7: An accepted uncorrected injection writes global status, bank address, bank misc and bank status. Bit 62 is set if the bank was already valid. The interrupt output goes high in the following cycle.
- R8: A corrected injection into a bank holding a valid uncorrected record only sets that bank's bit 62. Address and misc are kept.
- R9: After reset, global control and every bank control word are all ones. All status, address and misc words are zero. Both outputs are low.
- R10: Register map: 0 capability (read-only, writes ignored), 1 global control, 2 global status, and 4+4*b+{0 control, 1 status, 2 address, 3 misc} for bank b. Writes take effect at the next edge. An injection update wins over a write to the same register in the same cycle.
- R11: The interrupt is a one-cycle pulse for each accepted uncorrected error. The reset request stays high until the block is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mce_en | input | 1 | Machine-check delivery enabled |
| inj_valid | input | 1 | Error record present this cycle |
| inj_bank | input | 8 | Target bank index |
| inj_status | input | 64 | Error status word |
| inj_gstatus | input | 64 | Global status value for an uncorrected error |
| inj_addr | input | 64 | Error address |
| inj_misc | input | 64 | Error misc value |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register index |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| mc_irq | output | 1 | Machine-check interrupt pulse |
| reset_req | output | 1 | Sticky system reset request |

## Verification
The hardest case to reach is the nested uncorrected error. It needs a bank that is unmasked at both control levels and a global status with the in-progress bit set, and it can only be observed once, because the reset request is sticky. The stimulus gets there by first logging an uncorrected error whose global-status value sets bit 2. After a reset, the bench writes bit 2 directly through the register port and then injects. The overflow path for corrected errors needs a bank that already holds a valid uncorrected record, so the bench builds that state with one accepted injection and follows it with a corrected one to the same bank.

// File: rtl/mce_pkg.sv
package mce_pkg;

    localparam int DATA_W        = 64;
    localparam int ST_VALID      = 63;
    localparam int ST_OVER       = 62;
    localparam int ST_UNCORR     = 61;
    localparam int GS_INPROG     = 2;
    localparam int CAP_CTL_PRES  = 8;

    localparam int REG_CAP       = 0;
    localparam int REG_GCTL      = 1;
    localparam int REG_GSTAT     = 2;
    localparam int BANK_BASE     = 4;
    localparam int REGS_PER_BANK = 4;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        word_t ctl;
        word_t status;
        word_t addr;
        word_t misc;
    } bank_t;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_LOG_UC,
        ACT_LOG_CE,
        ACT_MARK_OVER,
        ACT_RESET
    } act_e;

    function automatic word_t set_over(word_t s, logic flag);
        word_t r;
        r = s;
        if (flag) r[ST_OVER] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/mce_decide.sv
module mce_decide
    import mce_pkg::*;
(
    input  logic       inj_valid,
    input  logic [7:0] inj_bank,
    input  word_t      inj_status,
    input  logic [7:0] bank_count,
    input  logic       ctl_present,
    input  logic       gctl_ones,
    input  logic       gstat_inprog,
    input  logic       mce_en,
    input  logic       bank_ctl_ones,
    input  word_t      bank_status,
    output act_e       act,
    output word_t      new_status
);
    logic is_uc, prev_valid, prev_uc, masked;

    always_comb begin
        is_uc      = inj_status[ST_UNCORR];
        prev_valid = bank_status[ST_VALID];
        prev_uc    = bank_status[ST_UNCORR];
        masked     = (ctl_present && !gctl_ones) || !bank_ctl_ones;
        act        = ACT_NONE;
        new_status = inj_status;
        if (!inj_valid || (inj_bank >= bank_count) || !inj_status[ST_VALID]) begin
            act = ACT_NONE;
        end else if (is_uc) begin
            if (masked) begin
                act = ACT_NONE;
            end else if (gstat_inprog || !mce_en) begin
                act = ACT_RESET;
            end else begin
                act        = ACT_LOG_UC;
                new_status = set_over(inj_status, prev_valid);
            end
        end else if (!prev_valid || !prev_uc) begin
            act        = ACT_LOG_CE;
            new_status = set_over(inj_status, prev_valid);
        end else begin
            act        = ACT_MARK_OVER;
            new_status = set_over(bank_status, 1'b1);
        end
    end

endmodule

// File: rtl/mce_regs.sv
module mce_regs
    import mce_pkg::*;
#(
    parameter int    NBANK     = 4,
    parameter int    AW        = 8,
    parameter word_t CAP_VALUE = 64'h103
) (
    input  logic          clk,
    input  logic          rst,
    input  act_e          act,
    input  logic [7:0]    inj_bank,
    input  word_t         new_status,
    input  word_t         inj_gstatus,
    input  word_t         inj_addr,
    input  word_t         inj_misc,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  word_t         reg_wdata,
    output word_t         reg_rdata,
    output logic          gctl_ones,
    output logic          gstat_inprog,
    output logic          sel_ctl_ones,
    output word_t         sel_status
);
    word_t gctl_q, gstat_q;
    bank_t banks [NBANK];

    logic do_log, do_mark;
    assign do_log  = (act == ACT_LOG_UC) || (act == ACT_LOG_CE);
    assign do_mark = (act == ACT_MARK_OVER);

    always_ff @(posedge clk) begin
        if (rst) begin
            gctl_q  <= '1;
            gstat_q <= '0;
        end else begin
            if (reg_we && reg_addr == AW'(REG_GCTL))  gctl_q  <= reg_wdata;
            if (reg_we && reg_addr == AW'(REG_GSTAT)) gstat_q <= reg_wdata;
            if (act == ACT_LOG_UC)                    gstat_q <= inj_gstatus;
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [AW-1:0] BASE = AW'(BANK_BASE + REGS_PER_BANK * b);
        bank_t r;
        logic  hit;
        assign hit = (inj_bank == 8'(b));
        always_ff @(posedge clk) begin
            if (rst) begin
                r.ctl    <= '1;
                r.status <= '0;
                r.addr   <= '0;
                r.misc   <= '0;
            end else begin
                if (reg_we && reg_addr == BASE)             r.ctl    <= reg_wdata;
                if (reg_we && reg_addr == BASE + AW'(1))    r.status <= reg_wdata;
                if (reg_we && reg_addr == BASE + AW'(2))    r.addr   <= reg_wdata;
                if (reg_we && reg_addr == BASE + AW'(3))    r.misc   <= reg_wdata;
                if (hit && do_log) begin
                    r.status <= new_status;
                    r.addr   <= inj_addr;
                    r.misc   <= inj_misc;
                end
                if (hit && do_mark) r.status <= new_status;
            end
        end
        assign banks[b] = r;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(REG_CAP))   reg_rdata = CAP_VALUE;
        if (reg_addr == AW'(REG_GCTL))  reg_rdata = gctl_q;
        if (reg_addr == AW'(REG_GSTAT)) reg_rdata = gstat_q;
        for (int b = 0; b < NBANK; b++) begin
            if (reg_addr == AW'(BANK_BASE + REGS_PER_BANK * b))     reg_rdata = banks[b].ctl;
            if (reg_addr == AW'(BANK_BASE + REGS_PER_BANK * b + 1)) reg_rdata = banks[b].status;
            if (reg_addr == AW'(BANK_BASE + REGS_PER_BANK * b + 2)) reg_rdata = banks[b].addr;
            if (reg_addr == AW'(BANK_BASE + REGS_PER_BANK * b + 3)) reg_rdata = banks[b].misc;
        end
    end

    always_comb begin
        sel_ctl_ones = 1'b0;
        sel_status   = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (inj_bank == 8'(b)) begin
                sel_ctl_ones = &banks[b].ctl;
                sel_status   = banks[b].status;
            end
        end
    end

    assign gctl_ones    = &gctl_q;
    assign gstat_inprog = gstat_q[GS_INPROG];

endmodule

// File: rtl/mce_bank_logger.sv
module mce_bank_logger
    import mce_pkg::*;
#(
    parameter int    NBANK     = 4,
    parameter int    AW        = 8,
    parameter word_t CAP_VALUE = 64'h103
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mce_en,
    input  logic          inj_valid,
    input  logic [7:0]    inj_bank,
    input  logic [63:0]   inj_status,
    input  logic [63:0]   inj_gstatus,
    input  logic [63:0]   inj_addr,
    input  logic [63:0]   inj_misc,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [63:0]   reg_wdata,
    output logic [63:0]   reg_rdata,
    output logic          mc_irq,
    output logic          reset_req
);
    localparam logic [7:0] CAP_COUNT  = CAP_VALUE[7:0];
    localparam logic [7:0] BANK_COUNT = (CAP_COUNT > 8'(NBANK)) ? 8'(NBANK) : CAP_COUNT;
    localparam logic       CTL_PRES   = CAP_VALUE[CAP_CTL_PRES];

    act_e  act;
    word_t new_status, sel_status;
    logic  gctl_ones, gstat_inprog, sel_ctl_ones;

    mce_regs #(.NBANK(NBANK), .AW(AW), .CAP_VALUE(CAP_VALUE)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .act          (act),
        .inj_bank     (inj_bank),
        .new_status   (new_status),
        .inj_gstatus  (inj_gstatus),
        .inj_addr     (inj_addr),
        .inj_misc     (inj_misc),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .gctl_ones    (gctl_ones),
        .gstat_inprog (gstat_inprog),
        .sel_ctl_ones (sel_ctl_ones),
        .sel_status   (sel_status)
    );

    mce_decide u_decide (
        .inj_valid     (inj_valid),
        .inj_bank      (inj_bank),
        .inj_status    (inj_status),
        .bank_count    (BANK_COUNT),
        .ctl_present   (CTL_PRES),
        .gctl_ones     (gctl_ones),
        .gstat_inprog  (gstat_inprog),
        .mce_en        (mce_en),
        .bank_ctl_ones (sel_ctl_ones),
        .bank_status   (sel_status),
        .act           (act),
        .new_status    (new_status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mc_irq    <= 1'b0;
            reset_req <= 1'b0;
        end else begin
            mc_irq <= (act == ACT_LOG_UC);
            if (act == ACT_RESET) reset_req <= 1'b1;
        end
    end

endmodule

// File: rtl/mce_bank_logger_chk.sv
module mce_bank_logger_chk (
    input logic clk,
    input logic rst,
    input logic mce_en,
    input logic inj_valid,
    input logic inj_val_bit,
    input logic inj_uc_bit,
    input logic mc_irq,
    input logic reset_req
);
    // R7: an interrupt only follows an accepted uncorrected record
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
        mc_irq |-> $past(inj_valid && inj_val_bit && inj_uc_bit && mce_en));

    // R11: reset request is sticky
    p_rst_hold_r11: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> reset_req);

    // R5: reset request only rises after an uncorrected injection
    p_rst_cause_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(reset_req) |-> $past(inj_valid && inj_val_bit && inj_uc_bit));

    // R5: no interrupt while delivery is disabled
    p_no_irq_disabled_r5: assert property (@(posedge clk) disable iff (rst)
        (inj_valid && !mce_en) |=> !mc_irq);

    // R2: an invalid record triggers neither output
    p_ignore_invalid_r2: assert property (@(posedge clk) disable iff (rst)
        (inj_valid && !inj_val_bit) |=> (!mc_irq && !$rose(reset_req)));

    // R11: escalation and interrupt never start together
    p_irq_rst_excl_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(reset_req) |-> !mc_irq);

endmodule

bind mce_bank_logger mce_bank_logger_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .mce_en      (mce_en),
    .inj_valid   (inj_valid),
    .inj_val_bit (inj_status[63]),
    .inj_uc_bit  (inj_status[61]),
    .mc_irq      (mc_irq),
    .reset_req   (reset_req)
);

// File: tb/mce_bank_logger_bench.sv
`timescale 1ns/1ps
module mce_bank_logger_bench;
    localparam logic [63:0] VAL  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] OVF  = 64'h4000_0000_0000_0000;
    localparam logic [63:0] UC   = 64'h2000_0000_0000_0000;
    localparam logic [63:0] ONES = '1;

    logic        clk = 1'b0, rst = 1'b1, mce_en = 1'b0;
    logic        inj_valid = 1'b0;
    logic [7:0]  inj_bank = '0;
    logic [63:0] inj_status = '0, inj_gstatus = '0, inj_addr = '0, inj_misc = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        mc_irq, reset_req;

    always #2 clk = ~clk;

    mce_bank_logger u_mce_bank_logger (
        .clk(clk), .rst(rst), .mce_en(mce_en), .inj_valid(inj_valid),
        .inj_bank(inj_bank), .inj_status(inj_status), .inj_gstatus(inj_gstatus),
        .inj_addr(inj_addr), .inj_misc(inj_misc), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mc_irq(mc_irq), .reset_req(reset_req)
    );

    typedef struct {
        string       tag;
        logic        chk_rd;
        logic [63:0] exp_rd;
        logic        exp_irq;
        logic        exp_rst;
    } item_t;

    item_t q[$];
    int    checks = 0, errors = 0;
    logic  exp_rst = 1'b0;
    bit    done = 0;

    function automatic logic [7:0] baddr(int b, int k);
        return 8'(4 + 4 * b + k);
    endfunction

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic push(string tag, logic chk, logic [63:0] e, logic irq);
        item_t it;
        it.tag = tag; it.chk_rd = chk; it.exp_rd = e; it.exp_irq = irq; it.exp_rst = exp_rst;
        q.push_back(it);
    endtask

    task automatic rd(logic [7:0] a, logic [63:0] e, string tag);
        reg_addr = a;
        push(tag, 1'b1, e, 1'b0);
        step();
    endtask

    task automatic wr(logic [7:0] a, logic [63:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic inject(logic [7:0] b, logic [63:0] st, logic [63:0] gs,
                          logic [63:0] ad, logic [63:0] mi, logic irq, logic rst_after, string tag);
        inj_valid = 1'b1; inj_bank = b; inj_status = st; inj_gstatus = gs;
        inj_addr = ad; inj_misc = mi;
        step();
        inj_valid = 1'b0;
        if (rst_after) exp_rst = 1'b1;
        push(tag, 1'b0, '0, irq);
        step();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        exp_rst = 1'b0;
    endtask

    // monitor: pops expected items and compares half a cycle after the edge
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                if (it.chk_rd) begin
                    checks++;
                    if (reg_rdata !== it.exp_rd) begin
                        errors++;
                        $display("FAIL %s rdata act=%h exp=%h", it.tag, reg_rdata, it.exp_rd);
                    end
                end
                checks++;
                if (mc_irq !== it.exp_irq) begin
                    errors++;
                    $display("FAIL %s mc_irq act=%b exp=%b", it.tag, mc_irq, it.exp_irq);
                end
                checks++;
                if (reset_req !== it.exp_rst) begin
                    errors++;
                    $display("FAIL %s reset_req act=%b exp=%b", it.tag, reset_req, it.exp_rst);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(); step(); step();
        rst = 1'b0;
        // R9 / R10 reset values and capability
        rd(8'd0, 64'h103, "R9 cap");
        rd(8'd1, ONES, "R9 gctl");
        rd(8'd2, 64'h0, "R9 gstat");
        rd(baddr(0,0), ONES, "R9 bank0 ctl");
        rd(baddr(2,0), ONES, "R9 bank2 ctl");
        rd(baddr(0,1), 64'h0, "R9 bank0 status");
        mce_en = 1'b1;

        // R6 corrected into empty bank, then overflow
        inject(8'd0, VAL | 64'h11, 64'h0, 64'h1000, 64'hAA, 1'b0, 1'b0, "R6 ce first");
        rd(baddr(0,1), VAL | 64'h11, "R6 status");
        rd(baddr(0,2), 64'h1000, "R6 addr");
        rd(baddr(0,3), 64'hAA, "R6 misc");
        inject(8'd0, VAL | 64'h22, 64'h77, 64'h2000, 64'hBB, 1'b0, 1'b0, "R6 ce second");
        rd(baddr(0,1), VAL | OVF | 64'h22, "R6 overflow");
        rd(baddr(0,2), 64'h2000, "R6 addr2");
        rd(8'd2, 64'h0, "R6 gstat untouched");

        // R7 uncorrected accepted
        inject(8'd1, VAL | UC | 64'h33, 64'h5, 64'h3000, 64'hCC, 1'b1, 1'b0, "R7 uc irq");
        rd(baddr(1,1), VAL | UC | 64'h33, "R7 status");
        rd(8'd2, 64'h5, "R7 gstat");
        rd(baddr(1,2), 64'h3000, "R7 addr");
        rd(baddr(1,3), 64'hCC, "R11 irq single pulse / R7 misc");

        // R8 corrected onto valid uncorrected record
        inject(8'd1, VAL | 64'h44, 64'h0, 64'h4000, 64'hDD, 1'b0, 1'b0, "R8 ce on uc");
        rd(baddr(1,1), VAL | UC | OVF | 64'h33, "R8 overflow only");
        rd(baddr(1,2), 64'h3000, "R8 addr kept");

        // R2 invalid record, R1 out-of-range banks
        inject(8'd2, 64'h55, 64'h0, 64'h5000, 64'hEE, 1'b0, 1'b0, "R2 invalid");
        rd(baddr(2,1), 64'h0, "R2 bank2 untouched");
        inject(8'd3, VAL | 64'h66, 64'h0, 64'h6000, 64'hFF, 1'b0, 1'b0, "R1 bank3");
        rd(baddr(3,1), 64'h0, "R1 bank3 untouched");
        inject(8'd200, VAL | UC | 64'h67, 64'h0, 64'h6100, 64'hF0, 1'b0, 1'b0, "R1 bank200");

        // R10 writes
        wr(8'd2, 64'h0);
        rd(8'd2, 64'h0, "R10 gstat write");
        wr(8'd0, 64'h0);
        rd(8'd0, 64'h103, "R10 cap read-only");

        // R3 global control mask
        wr(8'd1, ~64'h1);
        rd(8'd1, ~64'h1, "R10 gctl write");
        inject(8'd2, VAL | UC | 64'h77, 64'h0, 64'h7000, 64'h1, 1'b0, 1'b0, "R3 masked");
        rd(baddr(2,1), 64'h0, "R3 bank2 untouched");
        wr(8'd1, ONES);

        // R4 bank control mask
        wr(baddr(2,0), 64'h0);
        inject(8'd2, VAL | UC | 64'h88, 64'h0, 64'h8000, 64'h2, 1'b0, 1'b0, "R4 masked");
        rd(baddr(2,1), 64'h0, "R4 bank2 untouched");
        wr(baddr(2,0), ONES);

        // R7 uncorrected overflow
        inject(8'd2, VAL | UC | 64'h99, 64'h0, 64'h9000, 64'h3, 1'b1, 1'b0, "R7 uc first");
        inject(8'd2, VAL | UC | 64'hAA, 64'h0, 64'hA000, 64'h4, 1'b1, 1'b0, "R7 uc second");
        rd(baddr(2,1), VAL | UC | OVF | 64'hAA, "R7 uc overflow");

        // R5 disabled delivery escalates, R11 sticky
        mce_en = 1'b0;
        inject(8'd0, VAL | UC | 64'h1, 64'h0, 64'hB000, 64'h5, 1'b0, 1'b1, "R5 disabled");
        rd(baddr(0,1), VAL | OVF | 64'h22, "R5 nothing logged");
        rd(8'd0, 64'h103, "R11 reset request sticky");
        do_reset();
        rd(baddr(0,1), 64'h0, "R9 after re-reset");

        // R5 nested machine check
        mce_en = 1'b1;
        wr(8'd2, 64'h4);
        inject(8'd0, VAL | UC | 64'h2, 64'h0, 64'hC000, 64'h6, 1'b0, 1'b1, "R5 nested");
        rd(baddr(0,1), 64'h0, "R5 nested nothing logged");

        step(); step();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule